// File: doc/BRIEF.md
# Indirect-Select Vectored Interrupt Controller

This block gathers up to 128 interrupt inputs, decides which of them should interrupt the processor, and drives one request line. No source has its own address. Software first writes a source number into a select register. Mode, vector, enable, disable, clear and set accesses then act on that one source. Each source has a 3-bit priority, a trigger type (high level, low level, rising edge or falling edge), an enable bit and a 32-bit vector.

The handler reads the active-vector register. This read returns the vector of the winning source and acknowledges it. The acknowledge pushes the winner's priority and number onto an 8-entry nesting stack and clears the winner's latched pending bit. From then on, only a strictly higher priority can raise the request again. Each end-of-interrupt write pops one stack level. If the request is low, the active-vector read returns a programmable spurious vector and changes nothing.

Top module: `isel_vic`

## Requirements
- R1: The select register at 0x00 holds a 7-bit source index in bits 6:0, and its upper bits read zero. While the index is not below the source count, per-source writes do nothing and per-source reads (0x04, 0x08, 0x30) return zero.
- R2: Mode register 0x04 and vector register 0x08 act on the selected source only. Mode bits 2:0 hold the priority and bits 6:5 the trigger type: 00 high level, 01 low level, 10 rising edge, 11 falling edge. All other mode bits read zero. The vector is 32 bits wide.
- R3: A write to 0x40 enables the selected source and a write to 0x44 disables it, whatever the data. Bit 0 of 0x30 reads the enable bit of the selected source.
- R4: A write to 0x48 clears the latched pending bit of the selected source. A write to 0x4C sets it, which acts as a software trigger.
- R5: A level source is pending while its input is at the active level, or while its latch is set. An edge source latches pending on the clock after the edge and stays pending until it is acknowledged or cleared.
- R6: Bit j of the word at 0x20+4k is the pending state of source 32k+j, whether or not that source is enabled. Bits for sources past the source count read zero.
- R7: irq_o is high exactly when some enabled pending source has a priority above the stack top, or when the stack is empty.
- R8: The winner is the enabled pending source with the highest priority. On a tie, the lowest source number wins. A read of 0x10 returns the winner's vector.
- R9: A read of 0x10 while irq_o is high acknowledges the winner. It pushes the winner onto the stack and clears the winner's latch. The request then stays low until a source of strictly higher priority is pending.
- R10: A read of 0x10 while irq_o is low returns the spurious vector and leaves all state unchanged. The spurious vector is a 32-bit read/write register at 0x3C.
- R11: Register 0x18 reads the source number at the stack top, and zero when the stack is empty.
- R12: A write to 0x38 pops one stack level and has no effect on an empty stack. Eight consecutive such writes always leave the stack empty. The stack never holds more than 8 entries.
- R13: After reset, every source is disabled and its latch is clear. All mode and vector registers, the select register and the spurious vector are zero, and the stack is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Interrupt source inputs |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write access, 0 for a read access |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the controller with 40 sources, so a loop over every source fits in the run. That loop covers each source's mode and vector readback, its enable, its software trigger, its acknowledge and its end-of-interrupt. With 40 sources the pending words include one that is only partly populated and two that read zero, which exercises the range limits of R1 and R6. Because priorities repeat modulo 8, ties and an 8-level nest followed by a lower-priority source that must wait can all be built from the same sources.

// File: rtl/isel_vic_pkg.sv
package isel_vic_pkg;

    localparam int unsigned PRIO_W = 3;
    localparam int unsigned VEC_W  = 32;
    localparam int unsigned BUS_W  = 32;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned IDX_W  = 7;

    localparam logic [ADDR_W-1:0] OFS_SEL   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_MODE  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_VEC   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_IVEC  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CUR   = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_PEND0 = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_PEND1 = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_PEND2 = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_PEND3 = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_EOI   = 8'h38;
    localparam logic [ADDR_W-1:0] OFS_SPUR  = 8'h3C;
    localparam logic [ADDR_W-1:0] OFS_EN    = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_DIS   = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h48;
    localparam logic [ADDR_W-1:0] OFS_SET   = 8'h4C;

    typedef enum logic [1:0] {
        TRIG_LVL_HI = 2'b00,
        TRIG_LVL_LO = 2'b01,
        TRIG_RISE   = 2'b10,
        TRIG_FALL   = 2'b11
    } trig_e;

    typedef struct packed {
        logic wr_mode;
        logic wr_vec;
        logic en;
        logic dis;
        logic clr;
        logic set;
        logic ack;
    } src_cmd_t;

endpackage

// File: rtl/isel_vic_src_bank.sv
module isel_vic_src_bank
    import isel_vic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 128,
    parameter int unsigned SIDX_W  = 7
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_SRC-1:0]              src_i,
    input  logic [SIDX_W-1:0]               sel_idx,
    input  logic                            sel_ok,
    input  src_cmd_t                        cmd,
    input  logic [BUS_W-1:0]                wdata,
    input  logic [SIDX_W-1:0]               ack_idx,
    output logic [NUM_SRC-1:0]              pend_o,
    output logic [NUM_SRC-1:0]              en_o,
    output logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_o,
    output logic [NUM_SRC-1:0][1:0]         trig_o,
    output logic [NUM_SRC-1:0][VEC_W-1:0]   vec_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0]             en;
        logic [NUM_SRC-1:0]             latch;
        logic [NUM_SRC-1:0]             prev;
        logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
        logic [NUM_SRC-1:0][1:0]        trig;
        logic [NUM_SRC-1:0][VEC_W-1:0]  vec;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d      = bank_q;
        bank_d.prev = src_i;
        for (int i = 0; i < NUM_SRC; i++) begin
            // acknowledge first so that a fresh edge in the same cycle survives
            if (cmd.ack && ack_idx == SIDX_W'(i)) begin
                bank_d.latch[i] = 1'b0;
            end
            if ((bank_q.trig[i] == TRIG_RISE &&  src_i[i] && !bank_q.prev[i]) ||
                (bank_q.trig[i] == TRIG_FALL && !src_i[i] &&  bank_q.prev[i])) begin
                bank_d.latch[i] = 1'b1;
            end
            if (sel_ok && sel_idx == SIDX_W'(i)) begin
                if (cmd.wr_mode) begin
                    bank_d.prio[i] = wdata[PRIO_W-1:0];
                    bank_d.trig[i] = wdata[6:5];
                end
                if (cmd.wr_vec) bank_d.vec[i]   = wdata;
                if (cmd.en)     bank_d.en[i]    = 1'b1;
                if (cmd.dis)    bank_d.en[i]    = 1'b0;
                if (cmd.clr)    bank_d.latch[i] = 1'b0;
                if (cmd.set)    bank_d.latch[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            pend_o[i] = bank_q.latch[i]
                      | (bank_q.trig[i] == TRIG_LVL_HI &&  src_i[i])
                      | (bank_q.trig[i] == TRIG_LVL_LO && !src_i[i]);
        end
    end

    assign en_o   = bank_q.en;
    assign prio_o = bank_q.prio;
    assign trig_o = bank_q.trig;
    assign vec_o  = bank_q.vec;

endmodule

// File: rtl/isel_vic_arbiter.sv
module isel_vic_arbiter
    import isel_vic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 128,
    parameter int unsigned SIDX_W  = 7
) (
    input  logic [NUM_SRC-1:0]             req_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
    output logic                           win_valid_o,
    output logic [SIDX_W-1:0]              win_idx_o,
    output logic [PRIO_W-1:0]              win_prio_o
);

    // ascending scan with a strict compare: on a tie the lower index stays
    always_comb begin
        win_valid_o = 1'b0;
        win_idx_o   = '0;
        win_prio_o  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req_i[i] && (!win_valid_o || prio_i[i] > win_prio_o)) begin
                win_valid_o = 1'b1;
                win_idx_o   = SIDX_W'(i);
                win_prio_o  = prio_i[i];
            end
        end
    end

endmodule

// File: rtl/isel_vic_nest_stack.sv
module isel_vic_nest_stack
    import isel_vic_pkg::*;
#(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned SIDX_W = 7,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [PRIO_W-1:0] push_prio_i,
    input  logic [SIDX_W-1:0] push_src_i,
    output logic [CNT_W-1:0]  depth_o,
    output logic              empty_o,
    output logic [PRIO_W-1:0] top_prio_o,
    output logic [SIDX_W-1:0] top_src_o
);

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic [SIDX_W-1:0] src;
    } entry_t;

    typedef struct packed {
        entry_t [DEPTH-1:0] ent;
        logic   [CNT_W-1:0] cnt;
    } stack_t;

    stack_t stk_d, stk_q;

    logic [CNT_W-1:0] cnt_m1;
    logic [PTR_W-1:0] top_ptr;
    logic [PTR_W-1:0] wr_ptr;

    assign cnt_m1  = stk_q.cnt - CNT_W'(1);
    assign top_ptr = cnt_m1[PTR_W-1:0];
    assign wr_ptr  = stk_q.cnt[PTR_W-1:0];

    always_comb begin
        stk_d = stk_q;
        if (push_i && stk_q.cnt < CNT_W'(DEPTH)) begin
            stk_d.ent[wr_ptr].prio = push_prio_i;
            stk_d.ent[wr_ptr].src  = push_src_i;
            stk_d.cnt              = stk_q.cnt + CNT_W'(1);
        end else if (pop_i && stk_q.cnt != '0) begin
            stk_d.cnt = cnt_m1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stk_q <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

    assign depth_o    = stk_q.cnt;
    assign empty_o    = (stk_q.cnt == '0);
    assign top_prio_o = empty_o ? '0 : stk_q.ent[top_ptr].prio;
    assign top_src_o  = empty_o ? '0 : stk_q.ent[top_ptr].src;

endmodule

// File: rtl/isel_vic.sv
module isel_vic
    import isel_vic_pkg::*;
#(
    parameter int unsigned NUM_SRC    = 128,
    parameter int unsigned NEST_DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [7:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_o
);

    localparam int unsigned SIDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int unsigned CNT_W    = $clog2(NEST_DEPTH + 1);
    localparam int unsigned PAD_BITS = 128;

    typedef struct packed {
        logic [IDX_W-1:0] sel;
        logic [VEC_W-1:0] spur;
    } regs_t;

    regs_t regs_d, regs_q;

    logic                            wr_acc, rd_acc;
    logic                            rd_ivec, wr_eoi;
    logic                            sel_ok;
    logic [SIDX_W-1:0]               sel_sub;
    logic [IDX_W-1:0]                sel_q;
    logic [VEC_W-1:0]                spur_val;
    src_cmd_t                        cmd;
    logic [NUM_SRC-1:0]              src_pend, src_en;
    logic [NUM_SRC-1:0][PRIO_W-1:0]  src_prio;
    logic [NUM_SRC-1:0][1:0]         src_trig;
    logic [NUM_SRC-1:0][VEC_W-1:0]   src_vec;
    logic                            win_valid;
    logic [SIDX_W-1:0]               win_idx;
    logic [PRIO_W-1:0]               win_prio;
    logic [CNT_W-1:0]                stk_depth;
    logic                            stk_empty;
    logic [PRIO_W-1:0]               top_prio;
    logic [SIDX_W-1:0]               top_src;
    logic                            req_live;
    logic [PAD_BITS-1:0]             pend_pad;

    // ---------------- bus decode ----------------
    assign wr_acc  = bus_sel &&  bus_wr;
    assign rd_acc  = bus_sel && !bus_wr;
    assign rd_ivec = rd_acc && bus_addr == OFS_IVEC;
    assign wr_eoi  = wr_acc && bus_addr == OFS_EOI;

    assign sel_q    = regs_q.sel;
    assign spur_val = regs_q.spur;
    assign sel_ok   = int'(regs_q.sel) < int'(NUM_SRC);
    assign sel_sub  = regs_q.sel[SIDX_W-1:0];

    always_comb begin
        cmd         = '0;
        cmd.wr_mode = wr_acc && bus_addr == OFS_MODE;
        cmd.wr_vec  = wr_acc && bus_addr == OFS_VEC;
        cmd.en      = wr_acc && bus_addr == OFS_EN;
        cmd.dis     = wr_acc && bus_addr == OFS_DIS;
        cmd.clr     = wr_acc && bus_addr == OFS_CLR;
        cmd.set     = wr_acc && bus_addr == OFS_SET;
        cmd.ack     = rd_ivec && req_live;
    end

    // ---------------- local registers ----------------
    always_comb begin
        regs_d = regs_q;
        if (wr_acc && bus_addr == OFS_SEL)  regs_d.sel  = bus_wdata[IDX_W-1:0];
        if (wr_acc && bus_addr == OFS_SPUR) regs_d.spur = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // ---------------- sub-blocks ----------------
    isel_vic_src_bank #(
        .NUM_SRC (NUM_SRC),
        .SIDX_W  (SIDX_W)
    ) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src_i),
        .sel_idx (sel_sub),
        .sel_ok  (sel_ok),
        .cmd     (cmd),
        .wdata   (bus_wdata),
        .ack_idx (win_idx),
        .pend_o  (src_pend),
        .en_o    (src_en),
        .prio_o  (src_prio),
        .trig_o  (src_trig),
        .vec_o   (src_vec)
    );

    isel_vic_arbiter #(
        .NUM_SRC (NUM_SRC),
        .SIDX_W  (SIDX_W)
    ) arb_i (
        .req_i       (src_pend & src_en),
        .prio_i      (src_prio),
        .win_valid_o (win_valid),
        .win_idx_o   (win_idx),
        .win_prio_o  (win_prio)
    );

    isel_vic_nest_stack #(
        .DEPTH  (NEST_DEPTH),
        .SIDX_W (SIDX_W)
    ) stk_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (cmd.ack),
        .pop_i       (wr_eoi),
        .push_prio_i (win_prio),
        .push_src_i  (win_idx),
        .depth_o     (stk_depth),
        .empty_o     (stk_empty),
        .top_prio_o  (top_prio),
        .top_src_o   (top_src)
    );

    assign req_live = win_valid && (stk_empty || win_prio > top_prio);
    assign irq_o    = req_live;

    // ---------------- read path ----------------
    always_comb begin
        pend_pad              = '0;
        pend_pad[NUM_SRC-1:0] = src_pend;
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_acc) begin
            unique case (bus_addr)
                OFS_SEL:  bus_rdata = 32'(regs_q.sel);
                OFS_MODE: if (sel_ok) begin
                              bus_rdata[PRIO_W-1:0] = src_prio[sel_sub];
                              bus_rdata[6:5]        = src_trig[sel_sub];
                          end
                OFS_VEC:  if (sel_ok) bus_rdata = src_vec[sel_sub];
                OFS_IVEC: bus_rdata = req_live ? src_vec[win_idx] : regs_q.spur;
                OFS_CUR:  bus_rdata = stk_empty ? '0 : 32'(top_src);
                OFS_PEND0, OFS_PEND1, OFS_PEND2, OFS_PEND3:
                          bus_rdata = pend_pad[{bus_addr[3:2], 5'b0} +: 32];
                OFS_MASK: bus_rdata = 32'(sel_ok && src_en[sel_sub]);
                OFS_SPUR: bus_rdata = regs_q.spur;
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/isel_vic_chk.sv
module isel_vic_chk
    import isel_vic_pkg::*;
#(
    parameter int unsigned NUM_SRC    = 128,
    parameter int unsigned NEST_DEPTH = 8,
    localparam int unsigned CNT_W     = $clog2(NEST_DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [7:0]         bus_addr,
    input logic [31:0]        bus_rdata,
    input logic               irq_o,
    input logic [CNT_W-1:0]   depth,
    input logic [31:0]        spur,
    input logic [NUM_SRC-1:0] en,
    input logic [IDX_W-1:0]   sel
);

    logic [127:0] en_pad;
    logic [3:0]   eoi_run;
    logic         rd_ivec, rd_cur, wr_eoi, wr_en, wr_dis, sel_in;

    always_comb begin
        en_pad              = '0;
        en_pad[NUM_SRC-1:0] = en;
    end

    assign rd_ivec = bus_sel && !bus_wr && bus_addr == OFS_IVEC;
    assign rd_cur  = bus_sel && !bus_wr && bus_addr == OFS_CUR;
    assign wr_eoi  = bus_sel &&  bus_wr && bus_addr == OFS_EOI;
    assign wr_en   = bus_sel &&  bus_wr && bus_addr == OFS_EN;
    assign wr_dis  = bus_sel &&  bus_wr && bus_addr == OFS_DIS;
    assign sel_in  = int'(sel) < int'(NUM_SRC);

    // run length of back-to-back end-of-interrupt writes, saturating at 8
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eoi_run <= '0;
        end else if (wr_eoi) begin
            if (eoi_run < 4'd8) eoi_run <= eoi_run + 4'd1;
        end else if (bus_sel) begin
            eoi_run <= '0;
        end
    end

    // R12
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= CNT_W'(NEST_DEPTH));

    // R12
    eoi_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_run == 4'd8) |-> depth == '0);

    // R9
    ack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ivec && irq_o) |=> depth == $past(depth) + CNT_W'(1));

    // R10
    spur_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ivec && !irq_o) |-> bus_rdata == spur);

    // R10
    spur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ivec && !irq_o) |=> depth == $past(depth));

    // R11
    cur_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cur && depth == '0) |-> bus_rdata == '0);

    // R3
    dis_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dis && sel_in) |=> !en_pad[$past(sel)]);

    // R3
    en_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_in) |=> en_pad[$past(sel)]);

endmodule

bind isel_vic isel_vic_chk #(
    .NUM_SRC    (NUM_SRC),
    .NEST_DEPTH (NEST_DEPTH)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .depth     (stk_depth),
    .spur      (spur_val),
    .en        (src_en),
    .sel       (sel_q)
);

// File: tb/isel_vic_tb_top.sv
module isel_vic_tb_top;

    localparam int NSRC = 40;

    localparam logic [7:0] A_SEL  = 8'h00, A_MODE = 8'h04, A_VEC = 8'h08;
    localparam logic [7:0] A_IVEC = 8'h10, A_CUR  = 8'h18, A_PEND = 8'h20;
    localparam logic [7:0] A_MASK = 8'h30, A_EOI  = 8'h38, A_SPUR = 8'h3C;
    localparam logic [7:0] A_EN   = 8'h40, A_DIS  = 8'h44, A_CLR  = 8'h48;
    localparam logic [7:0] A_SET  = 8'h4C;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src = '0;
    logic            bus_sel = 1'b0;
    logic            bus_wr = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    isel_vic #(.NUM_SRC(NSRC), .NEST_DEPTH(8)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic irq_check(input string req, input logic exp);
        #1 check(req, 32'(irq), 32'(exp));
    endtask

    function automatic logic [31:0] mode_val(input int i);
        return 32'((i % 8) | ((i % 4) << 5));
    endfunction

    function automatic logic [31:0] sweep_vec(input int i);
        return 32'hA500_0000 ^ (32'(i) * 32'h1234);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R13 reset state
        irq_check("R13 irq", 1'b0);
        rd_check("R13 sel", A_SEL, 32'h0);
        rd_check("R13 mode", A_MODE, 32'h0);
        rd_check("R13 vec", A_VEC, 32'h0);
        rd_check("R13 mask", A_MASK, 32'h0);
        for (int k = 0; k < 4; k++) rd_check("R13 pend", A_PEND + 8'(4 * k), 32'h0);
        rd_check("R13 cur", A_CUR, 32'h0);
        rd_check("R13 ivec spurious zero", A_IVEC, 32'h0);

        // R2 per-source mode/vector, extra mode bits dropped
        for (int i = 0; i < NSRC; i++) begin
            wr(A_SEL, 32'(i));
            wr(A_MODE, mode_val(i) | 32'hFFFF_FF98);
            wr(A_VEC, sweep_vec(i));
        end
        for (int i = 0; i < NSRC; i++) begin
            wr(A_SEL, 32'(i));
            rd_check("R2 mode readback", A_MODE, mode_val(i));
            rd_check("R2 vec readback", A_VEC, sweep_vec(i));
        end

        // R6 / R5: low-level sources (i%4==1) pend with inputs low, enable ignored
        rd_check("R6 pend word0", A_PEND, 32'h2222_2222);
        rd_check("R6 pend word1", A_PEND + 8'h4, 32'h0000_0022);
        rd_check("R6 pend word2", A_PEND + 8'h8, 32'h0);
        rd_check("R6 pend word3", A_PEND + 8'hC, 32'h0);
        irq_check("R7 no enabled source", 1'b0);

        // rising-edge mode, priority i%8, vector 0x1000+i
        for (int i = 0; i < NSRC; i++) begin
            wr(A_SEL, 32'(i));
            wr(A_MODE, 32'h40 | 32'(i % 8));
            wr(A_VEC, 32'h1000 + 32'(i));
        end

        // R1 select width and out-of-range select
        wr(A_SEL, 32'hFFFF_FF85);
        rd_check("R1 sel masked", A_SEL, 32'h5);
        rd_check("R1 sel 5 mode", A_MODE, 32'h45);
        wr(A_SEL, 32'd50);
        rd_check("R1 sel 50", A_SEL, 32'd50);
        wr(A_MODE, 32'h7);
        wr(A_EN, 32'h0);
        rd_check("R1 out of range mode", A_MODE, 32'h0);
        rd_check("R1 out of range vec", A_VEC, 32'h0);
        rd_check("R1 out of range mask", A_MASK, 32'h0);
        irq_check("R1 no irq", 1'b0);

        // R3 data ignored on enable/disable
        wr(A_SEL, 32'd7);
        wr(A_EN, 32'h0);
        rd_check("R3 enable", A_MASK, 32'h1);
        wr(A_DIS, 32'hFFFF_FFFF);
        rd_check("R3 disable", A_MASK, 32'h0);

        // R4 / R7 set on disabled source, then clear
        wr(A_SEL, 32'd5);
        wr(A_SET, 32'h0);
        irq_check("R7 disabled pending", 1'b0);
        rd_check("R4 set pends", A_PEND, 32'h20);
        wr(A_CLR, 32'h0);
        rd_check("R4 clear", A_PEND, 32'h0);

        // R8 R9 R11 R12 every source in turn
        for (int i = 0; i < NSRC; i++) begin
            wr(A_SEL, 32'(i));
            wr(A_EN, 32'h0);
            wr(A_SET, 32'h0);
            rd_check("R6 single pend", A_PEND + 8'(4 * (i / 32)), 32'h1 << (i % 32));
            irq_check("R7 raise", 1'b1);
            rd_check("R8 vector", A_IVEC, 32'h1000 + 32'(i));
            irq_check("R9 drop after ack", 1'b0);
            rd_check("R11 current", A_CUR, 32'(i));
            rd_check("R9 latch cleared", A_PEND + 8'(4 * (i / 32)), 32'h0);
            wr(A_EOI, 32'h0);
            rd_check("R12 pop", A_CUR, 32'h0);
            wr(A_DIS, 32'h0);
        end

        // R8 tie: sources 3 and 11 both priority 3
        wr(A_SEL, 32'd11); wr(A_EN, 32'h0); wr(A_SET, 32'h0);
        wr(A_SEL, 32'd3);  wr(A_EN, 32'h0); wr(A_SET, 32'h0);
        irq_check("R7 tie raise", 1'b1);
        rd_check("R8 tie lowest index", A_IVEC, 32'h1003);
        irq_check("R9 equal prio blocked", 1'b0);
        rd_check("R11 tie current", A_CUR, 32'd3);
        wr(A_EOI, 32'h0);
        irq_check("R7 after pop", 1'b1);
        rd_check("R8 tie second", A_IVEC, 32'h100B);
        rd_check("R11 tie current 2", A_CUR, 32'd11);
        wr(A_EOI, 32'h0);
        wr(A_DIS, 32'h0);
        wr(A_SEL, 32'd11); wr(A_DIS, 32'h0);

        // R9 R12 full 8-level nest, then a priority-0 source waits
        for (int k = 0; k < 8; k++) begin
            wr(A_SEL, 32'(k)); wr(A_EN, 32'h0); wr(A_SET, 32'h0);
            irq_check("R9 higher prio preempts", 1'b1);
            rd_check("R8 nest vector", A_IVEC, 32'h1000 + 32'(k));
            rd_check("R11 nest current", A_CUR, 32'(k));
        end
        wr(A_SEL, 32'd8); wr(A_EN, 32'h0); wr(A_SET, 32'h0);
        irq_check("R9 lower prio held", 1'b0);
        rd_check("R10 spurious while held", A_IVEC, 32'h0);
        for (int k = 7; k >= 0; k--) begin
            rd_check("R11 unwind current", A_CUR, 32'(k));
            wr(A_EOI, 32'h0);
        end
        rd_check("R12 unwound", A_CUR, 32'h0);
        irq_check("R7 empty stack prio 0", 1'b1);
        rd_check("R8 prio 0 vector", A_IVEC, 32'h1008);
        wr(A_EOI, 32'h0);
        wr(A_EOI, 32'h0);
        rd_check("R12 eoi on empty", A_CUR, 32'h0);
        irq_check("R12 quiet", 1'b0);

        // R12 eight back-to-back EOIs from a 3-deep stack
        for (int k = 5; k < 8; k++) begin
            wr(A_SEL, 32'(k)); wr(A_SET, 32'h0);
            rd_check("R8 relaunch", A_IVEC, 32'h1000 + 32'(k));
        end
        for (int k = 0; k < 8; k++) wr(A_EOI, 32'h0);
        rd_check("R12 eight eoi", A_CUR, 32'h0);
        for (int k = 0; k < 9; k++) begin
            wr(A_SEL, 32'(k)); wr(A_DIS, 32'h0);
        end

        // R5 high level on source 20 (prio 4)
        wr(A_SEL, 32'd20); wr(A_MODE, 32'h04); wr(A_EN, 32'h0);
        @(negedge clk); src[20] = 1'b1;
        irq_check("R5 level high raise", 1'b1);
        rd_check("R5 level pend", A_PEND, 32'h1 << 20);
        rd_check("R8 level vector", A_IVEC, 32'h1014);
        irq_check("R9 level acked", 1'b0);
        wr(A_EOI, 32'h0);
        irq_check("R5 level still high", 1'b1);
        @(negedge clk); src[20] = 1'b0;
        irq_check("R5 level released", 1'b0);
        rd_check("R5 level gone", A_PEND, 32'h0);
        wr(A_DIS, 32'h0);

        // R5 low level on source 21
        wr(A_SEL, 32'd21); wr(A_MODE, 32'h24);
        rd_check("R5 low level pend", A_PEND, 32'h1 << 21);
        wr(A_EN, 32'h0);
        irq_check("R5 low level raise", 1'b1);
        @(negedge clk); src[21] = 1'b1;
        irq_check("R5 low level released", 1'b0);
        wr(A_MODE, 32'h45);
        wr(A_DIS, 32'h0);
        @(negedge clk); src[21] = 1'b0;

        // R5 R4 rising edge on 22, falling edge on 23
        wr(A_SEL, 32'd22); wr(A_MODE, 32'h46);
        @(negedge clk); src[22] = 1'b1;
        @(negedge clk); src[22] = 1'b0;
        rd_check("R5 rising latched", A_PEND, 32'h1 << 22);
        wr(A_CLR, 32'h0);
        rd_check("R4 rising cleared", A_PEND, 32'h0);
        wr(A_SEL, 32'd23); wr(A_MODE, 32'h67);
        @(negedge clk); src[23] = 1'b1;
        rd_check("R5 falling ignores rise", A_PEND, 32'h0);
        @(negedge clk); src[23] = 1'b0;
        rd_check("R5 falling latched", A_PEND, 32'h1 << 23);
        wr(A_CLR, 32'h0);
        rd_check("R4 falling cleared", A_PEND, 32'h0);

        // R10 spurious vector
        wr(A_SPUR, 32'hDEAD_BEEF);
        rd_check("R10 spurious readback", A_SPUR, 32'hDEAD_BEEF);
        irq_check("R10 idle", 1'b0);
        rd_check("R10 spurious vector", A_IVEC, 32'hDEAD_BEEF);
        rd_check("R10 no push", A_CUR, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule